// File: doc/BRIEF.md
# Switch-Node Window Segment Controller

This block sets how many parallel power-switch subcells of a synchronous buck stage take part in conduction. Once per switching period an external pair of comparators looks at the phase-node voltage while the low-side switch is on and reports whether that sample lies above an upper threshold or below a lower one. The results are latched outside the block and offered together with a single-cycle strobe. The block steps the number of enabled subcell groups up or down, one group at a time, so that the sampled voltage returns inside the window. No load-current sensor or converter is needed, and on-resistance drift is absorbed automatically, because the drop across the switch is the quantity being regulated.

The enable output is a thermometer code. One group is wired permanently on, and `NGRP` switchable groups sit above it. After every change the block ignores a fixed number of strobes so that the stage can settle. When the minimum count is reached and the sample keeps falling below the window, the block requests light-load pulse-frequency operation. A repeated over-window sample while in that mode brings back every group in one step, to protect the stage during a load step.

Top module: `seg_pin_ctrl`

## Requirements
- R1: `cell_en` is a thermometer code. Bit i (1 ≤ i ≤ NGRP) is 1 exactly when the active group count is at least i.
- R2: `cell_en[0]` drives the permanent group and is 1 in every cycle, including during and just after reset.
- R3: While `rst_n` is low, all NGRP groups are enabled and `pfm_req` is 0.
- R4: In width-modulated mode, a strobe that falls outside the guard period acts as follows. `cmp_hi` raises the count by one, saturating at NGRP. `cmp_lo` without `cmp_hi` lowers it by one, saturating at 0. When both are high, `cmp_hi` wins. When neither is high, the count holds. One decision changes at most one group.
- R5: In a cycle with `cyc_tick` low, the count, the mode, the guard period and the run counts are left unchanged, whatever the comparator inputs are.
- R6: After any change of the count, the next GUARD_TICKS (4) strobes are ignored. The strobe after them is acted on.
- R7: At count 0, PFM_ENTRY_RUN (8) consecutive unguarded strobes with `cmp_lo` high and `cmp_hi` low raise `pfm_req` on the last of them. Any other strobe restarts the run.
- R8: While `pfm_req` is 1, the count stays at 0 and `cmp_lo` is ignored. PFM_EXIT_RUN (2) consecutive strobes with `cmp_hi` high clear `pfm_req` and enable all groups in the same cycle, and a guard period starts. A strobe without `cmp_hi` restarts the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cyc_tick | input | 1 | One-cycle strobe per switching period, marking valid comparator results |
| cmp_hi | input | 1 | Latched sample lies above the upper threshold |
| cmp_lo | input | 1 | Latched sample lies below the lower threshold |
| cell_en | output | NGRP+1 | Thermometer subcell enables; bit 0 is the permanent group |
| pfm_req | output | 1 | Request for pulse-frequency operation |

## Verification
The stepping rule is driven with separate patterns: over-window strobes at full count, which must saturate; under-window strobes that walk the count down to zero; simultaneous flags, which must resolve upward; and in-band strobes, which must hold. Strobes arriving during guard periods, and comparator activity with no strobe at all, separate a missing or mis-timed guard from true decisions. Runs toward light-load entry are broken by an in-band strobe to prove that the samples must be consecutive. Inside pulse-frequency mode, a lone high sample, a high sample followed by an in-band strobe, and a high pair separated by a strobe-free cycle tell the exit rule apart from a plain edge detector.

// File: rtl/seg_pin_pkg.sv
package seg_pin_pkg;
  typedef enum logic {
    MODE_PWM = 1'b0,
    MODE_PFM = 1'b1
  } seg_mode_e;
endpackage

// File: rtl/seg_run_counter.sv
module seg_run_counter #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int W = $clog2(RUN_LEN + 1);

  logic [W-1:0] run_q, run_d;

  always_comb hit = inc && (run_q == W'(RUN_LEN - 1));

  always_comb begin
    run_d = run_q;
    if (clr)      run_d = '0;
    else if (inc) run_d = hit ? '0 : run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (clr || inc) run_q <= run_d;
  end
endmodule

// File: rtl/seg_guard_timer.sv
module seg_guard_timer #(
  parameter int GUARD_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic busy
);
  localparam int W = $clog2(GUARD_TICKS + 1);

  logic [W-1:0] left_q, left_d;

  always_comb busy = (left_q != '0);

  always_comb begin
    left_d = left_q;
    if (load)              left_d = W'(GUARD_TICKS);
    else if (tick && busy) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left_q <= '0;
    else if (load || tick) left_q <= left_d;
  end
endmodule

// File: rtl/seg_therm_dec.sv
module seg_therm_dec #(
  parameter int NGRP  = 8,
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] count,
  output logic [NGRP:0]    therm
);
  assign therm[0] = 1'b1;

  for (genvar i = 1; i <= NGRP; i++) begin : g_bit
    assign therm[i] = (count >= CNT_W'(i));
  end
endmodule

// File: rtl/seg_pin_ctrl.sv
module seg_pin_ctrl
  import seg_pin_pkg::*;
#(
  parameter int NGRP          = 8,
  parameter int GUARD_TICKS   = 4,
  parameter int PFM_ENTRY_RUN = 8,
  parameter int PFM_EXIT_RUN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_tick,
  input  logic          cmp_hi,
  input  logic          cmp_lo,
  output logic [NGRP:0] cell_en,
  output logic          pfm_req
);
  localparam int CNT_W = $clog2(NGRP + 1);

  seg_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             guard_busy, guard_load;
  logic             act, step_up, step_dn;
  logic             lo_inc, lo_clr, lo_hit;
  logic             hi_inc, hi_clr, hi_hit;
  logic             at_max, at_min;

  always_comb begin
    at_max  = (cnt_q == CNT_W'(NGRP));
    at_min  = (cnt_q == '0);
    act     = cyc_tick && (mode_q == MODE_PWM) && !guard_busy;
    step_up = act && cmp_hi && !at_max;
    step_dn = act && !cmp_hi && cmp_lo && !at_min;
    lo_inc  = act && !cmp_hi && cmp_lo && at_min;
    lo_clr  = (mode_q == MODE_PFM) || (cyc_tick && !lo_inc);
    hi_inc  = cyc_tick && (mode_q == MODE_PFM) && cmp_hi;
    hi_clr  = (mode_q == MODE_PWM) || (cyc_tick && !cmp_hi);
    guard_load = step_up || step_dn || hi_hit;
  end

  always_comb begin
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (hi_hit) begin
      cnt_d  = CNT_W'(NGRP);
      mode_d = MODE_PWM;
    end else if (step_up) begin
      cnt_d = cnt_q + 1'b1;
    end else if (step_dn) begin
      cnt_d = cnt_q - 1'b1;
    end else if (lo_hit) begin
      mode_d = MODE_PFM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(NGRP);
      mode_q <= MODE_PWM;
    end else if (cyc_tick) begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  seg_guard_timer #(.GUARD_TICKS(GUARD_TICKS)) u_guard (
    .clk(clk), .rst_n(rst_n), .load(guard_load), .tick(cyc_tick), .busy(guard_busy)
  );

  seg_run_counter #(.RUN_LEN(PFM_ENTRY_RUN)) u_lo_run (
    .clk(clk), .rst_n(rst_n), .clr(lo_clr), .inc(lo_inc), .hit(lo_hit)
  );

  seg_run_counter #(.RUN_LEN(PFM_EXIT_RUN)) u_hi_run (
    .clk(clk), .rst_n(rst_n), .clr(hi_clr), .inc(hi_inc), .hit(hi_hit)
  );

  seg_therm_dec #(.NGRP(NGRP), .CNT_W(CNT_W)) u_therm (
    .count(cnt_q), .therm(cell_en)
  );

  assign pfm_req = (mode_q == MODE_PFM);
endmodule

// File: rtl/seg_pin_ctrl_chk.sv
module seg_pin_ctrl_chk #(
  parameter int NGRP = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_tick,
  input logic [NGRP:0] cell_en,
  input logic          pfm_req
);
  logic [NGRP:0] en_plus1;
  assign en_plus1 = cell_en + 1'b1;

  AST_PERM_ON: assert property (@(posedge clk) cell_en[0]); // R2

  AST_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en & en_plus1) == '0); // R1

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfm_req && $past(!pfm_req)) |-> ($countones(cell_en ^ $past(cell_en)) <= 1)); // R4

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_tick |=> ($stable(cell_en) && $stable(pfm_req))); // R5

  AST_PFM_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfm_req) |-> (cell_en == (NGRP+1)'(1))); // R7

  AST_PFM_EXIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pfm_req) |-> (&cell_en)); // R8
endmodule

bind seg_pin_ctrl seg_pin_ctrl_chk #(.NGRP(NGRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .cell_en(cell_en), .pfm_req(pfm_req)
);

// File: tb/seg_pin_ctrl_tb.sv
module seg_pin_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NG    = 8;

  logic clk, rst_n, cyc_tick, cmp_hi, cmp_lo;
  logic [NG:0] cell_en;
  logic pfm_req;
  int checks = 0;
  int errors = 0;

  seg_pin_ctrl #(.NGRP(NG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .cmp_hi(cmp_hi),
    .cmp_lo(cmp_lo), .cell_en(cell_en), .pfm_req(pfm_req)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // rows: tick, hi, lo, repeats, expected count, expected pfm_req
  localparam int NV = 10;
  localparam int VEC [NV][6] = '{
    '{1,1,0,1,8,0},   // R4 saturate at full
    '{1,0,1,1,7,0},   // R4 step down
    '{1,0,1,4,7,0},   // R6 guarded
    '{1,0,1,1,6,0},   // R6 fifth strobe acts
    '{0,0,1,3,6,0},   // R5 no strobe
    '{1,1,0,4,6,0},   // R6 guard not advanced by idle cycles
    '{1,1,0,1,7,0},   // R4 step up
    '{1,0,0,4,7,0},   // R4 in band, guard drains
    '{1,1,1,1,8,0},   // R4 high wins over low
    '{1,0,0,4,8,0}    // R4 hold
  };

  task automatic step(input logic t, input logic h, input logic l);
    cyc_tick = t; cmp_hi = h; cmp_lo = l;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int exp_cnt, input logic exp_pfm);
    logic [NG:0] exp_en;
    exp_en = (NG+1)'((1 << (exp_cnt + 1)) - 1);
    checks++;
    if (cell_en !== exp_en || pfm_req !== exp_pfm) begin
      errors++;
      $display("FAIL %s R1: cell_en=%b pfm_req=%b expected cell_en=%b pfm_req=%b",
               tag, cell_en, pfm_req, exp_en, exp_pfm);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_tick = 1'b0; cmp_hi = 1'b0; cmp_lo = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 reset state", 8, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 after release", 8, 1'b0);

    for (int v = 0; v < NV; v++)
      for (int r = 0; r < VEC[v][3]; r++) begin
        step(1'(VEC[v][0]), 1'(VEC[v][1]), 1'(VEC[v][2]));
        chk($sformatf("R4 vector %0d", v), VEC[v][4], 1'(VEC[v][5]));
      end

    // walk down to the permanent group only
    for (int k = 7; k >= 0; k--) begin
      step(1, 0, 1);
      chk("R4 descend", k, 1'b0);
      for (int g = 0; g < 4; g++) begin
        step(1, 0, 1);
        chk("R6 guard while descending", k, 1'b0);
      end
    end
    chk("R2 permanent group only", 0, 1'b0);

    // broken run toward light load
    for (int i = 0; i < 5; i++) begin step(1, 0, 1); chk("R7 partial run", 0, 1'b0); end
    step(1, 0, 0); chk("R7 in-band breaks run", 0, 1'b0);
    for (int i = 0; i < 7; i++) begin step(1, 0, 1); chk("R7 run below limit", 0, 1'b0); end
    step(0, 0, 1); chk("R5 idle cycle in run", 0, 1'b0);
    step(1, 0, 1); chk("R7 eighth low sample", 0, 1'b1);

    // light-load mode behaviour
    for (int i = 0; i < 3; i++) begin step(1, 0, 1); chk("R8 low ignored in PFM", 0, 1'b1); end
    step(1, 1, 0); chk("R8 single high", 0, 1'b1);
    step(1, 0, 0); chk("R8 run broken", 0, 1'b1);
    step(1, 1, 0); chk("R8 first high", 0, 1'b1);
    step(0, 1, 0); chk("R5 no strobe in PFM", 0, 1'b1);
    step(1, 1, 1); chk("R8 exit to full", 8, 1'b0);
    for (int g = 0; g < 4; g++) begin step(1, 0, 1); chk("R8 guard after exit", 8, 1'b0); end
    step(1, 0, 1); chk("R6 decision after exit guard", 7, 1'b0);

    // reset in the middle of operation
    rst_n = 1'b0;
    @(negedge clk);
    chk("R3 mid-run reset", 8, 1'b0);
    rst_n = 1'b1;
    step(1, 0, 1); chk("R4 first decision after reset", 7, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule